// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block is the code-fetch half of a bus interface unit for a 16-bit segmented processor. It keeps a six-byte first-in first-out buffer of code that has already been fetched, and it refills that buffer from memory on its own while the execution side is busy decoding or executing. Each fetch address is a 20-bit physical address, formed from a 16-bit code segment and a 16-bit fetch offset. The execution side takes bytes one at a time through a valid/ready port, and it reads the architectural instruction pointer on a separate output.

The memory side is a single request/acknowledge channel with at most one access outstanding. The execution side can also place its own data reads and writes on that channel, and these win over prefetch whenever both are waiting. A 16-bit bus mode and an 8-bit bus mode select how much free room the buffer needs before a refill and how many bytes each refill brings. A flush input, used on taken jumps, calls and returns, empties the buffer, loads a new segment and offset, and discards the result of any fetch still in flight.

Top module: `prefetch_queue`

## Requirements
- R1: After reset byteValid is 0, memReq is 0 and ipOut equals the reset offset parameter. The first request fetches from the reset segment and offset parameters.
- R2: A fetch address equals (segment × 16 + offset) modulo 2^20. For example, segment 5000h with offset 4321h gives 54321h.
- R3: The buffer holds at most 6 bytes. Bytes leave in the order they were fetched, which is increasing offset.
- R4: With busWide=1, a fetch starts only when at least 2 bytes are free. A fetch at an even offset is a word access (memByte=0): memRdata[7:0] is the byte at the even address and memRdata[15:8] is the next byte.
- R5: With busWide=1, a fetch at an odd offset is a byte access (memByte=1). Its byte is taken from memRdata[15:8], and the next fetch is at the following even offset.
- R6: With busWide=0, a fetch starts as soon as 1 byte is free. It is always a byte access (memByte=1), and its byte is taken from memRdata[7:0].
- R7: When dataReq is high at the point where a new request is chosen, the data access goes out before any prefetch. The access uses memWe=dataWe, memByte=dataByte, memAddr=dataAddr and memWdata=dataWdata. dataDone pulses with its memAck, and dataRdata carries memRdata.
- R8: flushReq empties the buffer, so byteValid is 0 in the next cycle. It loads flushSeg and flushOff as the new fetch position. Bytes returned by a fetch that was in flight are never delivered, and a byte offered in the flush cycle is not consumed.
- R9: The fetch offset wraps from FFFFh to 0000h without changing the segment.
- R10: ipOut is the offset of the byte at the head of the buffer, which is the fetch offset minus the buffer occupancy. It advances by one per consumed byte.
- R11: Only one request is outstanding at a time. memAddr, memByte and memWe stay stable from the request until memAck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWide | input | 1 | 1: 16-bit bus mode, 0: 8-bit bus mode |
| flushReq | input | 1 | Flush the buffer and reload the fetch position |
| flushSeg | input | 16 | New code segment on flush |
| flushOff | input | 16 | New fetch offset on flush |
| byteValid | output | 1 | Head byte available |
| byteData | output | 8 | Head byte |
| byteReady | input | 1 | Execution side takes the head byte |
| ipOut | output | 16 | Offset of the head byte |
| dataReq | input | 1 | Execution-side data access request, held until dataDone |
| dataWe | input | 1 | Data access is a write |
| dataByte | input | 1 | Data access is a single byte |
| dataAddr | input | 20 | Data access physical address |
| dataWdata | input | 16 | Data access write value |
| dataDone | output | 1 | Data access acknowledged |
| dataRdata | output | 16 | Data access read value |
| memReq | output | 1 | Memory request outstanding |
| memAddr | output | 20 | Memory byte address |
| memWe | output | 1 | Memory write |
| memByte | output | 1 | Single-byte access |
| memWdata | output | 16 | Memory write value |
| memAck | input | 1 | Memory acknowledge, one cycle |
| memRdata | input | 16 | Memory read value, valid with memAck |

## Verification
The hardest case to reach is a flush that lands while a fetch is still waiting for its acknowledge. A stale acknowledge that arrives after the reload must be dropped without moving the offset. To get there, the bench stretches the memory latency to several cycles, waits until a request is visibly pending, and then flushes to an odd offset. The scoreboard, which was refilled with the new byte stream, shows whether any old byte leaks out. The request log shows the byte-wide then word-wide realignment. The bench also holds the consumer stalled until the buffer is full and then releases single bytes, so that the one-free and two-free thresholds can be told apart in each bus mode.

// File: rtl/fq_pkg.sv
package fq_pkg;
  typedef struct packed {
    logic flush;
    logic push;
    logic pushTwo;
    logic hiLane;
  } fqStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_DATA} busState_t;
endpackage

// File: rtl/fq_datapath.sv
module fq_datapath
  import fq_pkg::*;
#(
  parameter int DEPTH   = 6,
  parameter int OFF_W   = 16,
  parameter int LANE_W  = 8,
  parameter logic [OFF_W-1:0] RST_SEG = '1,
  parameter logic [OFF_W-1:0] RST_OFF = '0,
  localparam int ADDR_W = OFF_W + 4,
  localparam int BUS_W  = 2 * LANE_W,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fqStrobe_t         strobe,
  input  logic [OFF_W-1:0]  flushSeg,
  input  logic [OFF_W-1:0]  flushOff,
  input  logic [BUS_W-1:0]  memRdata,
  input  logic              byteReady,
  output logic              byteValid,
  output logic [LANE_W-1:0] byteData,
  output logic [OFF_W-1:0]  ipOut,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchOdd,
  output logic [CNT_W-1:0]  freeSlots
);
  logic [LANE_W-1:0] slotMem [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [CNT_W-1:0]  count, pushCount;
  logic [OFF_W-1:0]  segReg, offReg;
  logic              popNow;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign byteValid = (count != '0);
  assign byteData  = slotMem[rdPtr];
  assign popNow    = byteValid && byteReady && !strobe.flush;
  assign pushCount = strobe.push ? (strobe.pushTwo ? CNT_W'(2) : CNT_W'(1)) : '0;
  assign freeSlots = CNT_W'(DEPTH) - count;
  assign ipOut     = offReg - OFF_W'(count);
  assign fetchAddr = {segReg, 4'h0} + ADDR_W'(offReg);
  assign fetchOdd  = offReg[0];

  always_ff @(posedge clk) begin
    if (strobe.push && !strobe.flush) begin
      if (strobe.pushTwo) begin
        slotMem[wrPtr]          <= memRdata[LANE_W-1:0];
        slotMem[nextPtr(wrPtr)] <= memRdata[BUS_W-1:LANE_W];
      end else begin
        slotMem[wrPtr] <= strobe.hiLane ? memRdata[BUS_W-1:LANE_W] : memRdata[LANE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr  <= '0;
      wrPtr  <= '0;
      count  <= '0;
      segReg <= RST_SEG;
      offReg <= RST_OFF;
    end else if (strobe.flush) begin
      rdPtr  <= '0;
      wrPtr  <= '0;
      count  <= '0;
      segReg <= flushSeg;
      offReg <= flushOff;
    end else begin
      if (strobe.push) begin
        wrPtr  <= strobe.pushTwo ? nextPtr(nextPtr(wrPtr)) : nextPtr(wrPtr);
        offReg <= offReg + OFF_W'(pushCount);
      end
      if (popNow) rdPtr <= nextPtr(rdPtr);
      count <= count + pushCount - CNT_W'(popNow);
    end
  end

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> !byteValid); // R8
  AST_IP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.flush |=> (ipOut == $past(ipOut) + OFF_W'($past(popNow)))); // R10
endmodule

// File: rtl/fq_control.sv
module fq_control
  import fq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BUS_W  = 16,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWide,
  input  logic              flushReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchOdd,
  input  logic [CNT_W-1:0]  freeSlots,
  input  logic              dataReq,
  input  logic              dataWe,
  input  logic              dataByte,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic [BUS_W-1:0]  dataWdata,
  input  logic              memAck,
  output fqStrobe_t         strobe,
  output logic              dataDone,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic              memByte,
  output logic [BUS_W-1:0]  memWdata
);
  busState_t state;
  logic      dropNext, reqTwo, reqHi, wantFetch;

  assign wantFetch = busWide ? (freeSlots >= CNT_W'(2)) : (freeSlots >= CNT_W'(1));
  assign memReq    = (state != ST_IDLE);
  assign dataDone  = (state == ST_DATA) && memAck;

  always_comb begin
    strobe.flush   = flushReq;
    strobe.push    = (state == ST_FETCH) && memAck && !dropNext && !flushReq;
    strobe.pushTwo = reqTwo;
    strobe.hiLane  = reqHi;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      dropNext <= 1'b0;
      reqTwo   <= 1'b0;
      reqHi    <= 1'b0;
      memAddr  <= '0;
      memWe    <= 1'b0;
      memByte  <= 1'b0;
      memWdata <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (dataReq) begin
            memAddr  <= dataAddr;
            memWe    <= dataWe;
            memByte  <= dataByte;
            memWdata <= dataWdata;
            state    <= ST_DATA;
          end else if (wantFetch && !flushReq) begin
            memAddr <= fetchAddr;
            memWe   <= 1'b0;
            memByte <= !busWide || fetchOdd;
            reqTwo  <= busWide && !fetchOdd;
            reqHi   <= busWide && fetchOdd;
            state   <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (memAck) begin
            state    <= ST_IDLE;
            dropNext <= 1'b0;
          end else if (flushReq) begin
            dropNext <= 1'b1;
          end
        end
        default: if (memAck) state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memByte) && $stable(memWe)); // R11
  AST_FETCH_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FETCH) |-> (freeSlots >= (memByte ? CNT_W'(1) : CNT_W'(2)))); // R4
  AST_DATA_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) && $past(dataReq) |-> (state == ST_DATA)); // R7
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import fq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int OFF_W = 16,
  parameter logic [OFF_W-1:0] RST_SEG = '1,
  parameter logic [OFF_W-1:0] RST_OFF = '0,
  localparam int LANE_W = 8,
  localparam int BUS_W  = 2 * LANE_W,
  localparam int ADDR_W = OFF_W + 4,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWide,
  input  logic              flushReq,
  input  logic [OFF_W-1:0]  flushSeg,
  input  logic [OFF_W-1:0]  flushOff,
  output logic              byteValid,
  output logic [LANE_W-1:0] byteData,
  input  logic              byteReady,
  output logic [OFF_W-1:0]  ipOut,
  input  logic              dataReq,
  input  logic              dataWe,
  input  logic              dataByte,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic [BUS_W-1:0]  dataWdata,
  output logic              dataDone,
  output logic [BUS_W-1:0]  dataRdata,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic              memByte,
  output logic [BUS_W-1:0]  memWdata,
  input  logic              memAck,
  input  logic [BUS_W-1:0]  memRdata
);
  fqStrobe_t         strobe;
  logic [ADDR_W-1:0] fetchAddr;
  logic              fetchOdd;
  logic [CNT_W-1:0]  freeSlots;

  assign dataRdata = memRdata;

  fq_datapath #(
    .DEPTH(DEPTH), .OFF_W(OFF_W), .LANE_W(LANE_W), .RST_SEG(RST_SEG), .RST_OFF(RST_OFF)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .flushSeg(flushSeg), .flushOff(flushOff),
    .memRdata(memRdata), .byteReady(byteReady), .byteValid(byteValid), .byteData(byteData),
    .ipOut(ipOut), .fetchAddr(fetchAddr), .fetchOdd(fetchOdd), .freeSlots(freeSlots)
  );

  fq_control #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .CNT_W(CNT_W)
  ) u_control (
    .clk(clk), .rstN(rstN), .busWide(busWide), .flushReq(flushReq), .fetchAddr(fetchAddr),
    .fetchOdd(fetchOdd), .freeSlots(freeSlots), .dataReq(dataReq), .dataWe(dataWe),
    .dataByte(dataByte), .dataAddr(dataAddr), .dataWdata(dataWdata), .memAck(memAck),
    .strobe(strobe), .dataDone(dataDone), .memReq(memReq), .memAddr(memAddr),
    .memWe(memWe), .memByte(memByte), .memWdata(memWdata)
  );
endmodule

// File: tb/prefetch_queue_bench.sv
module prefetch_queue_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic busWide = 1'b1, flushReq = 1'b0, byteReady = 1'b0;
  logic [15:0] flushSeg = '0, flushOff = '0;
  logic byteValid, dataDone, memReq, memWe, memByte;
  logic [7:0] byteData;
  logic [15:0] ipOut, dataRdata, memWdata;
  logic [19:0] memAddr;
  logic dataReq = 1'b0, dataWe = 1'b0, dataByte = 1'b0;
  logic [19:0] dataAddr = '0;
  logic [15:0] dataWdata = '0;
  logic memAck = 1'b0;
  logic [15:0] memRdata = '0;

  int checks = 0, errors = 0, lat = 1, cycles = 0;
  logic [7:0]  expByte[$];
  logic [15:0] expIp[$];
  logic [19:0] logAddr[$];
  logic        logByte[$];
  logic        logWe[$];
  logic [15:0] logWdata[$];

  prefetch_queue u_prefetch_queue (
    .clk(clk), .rstN(rstN), .busWide(busWide), .flushReq(flushReq), .flushSeg(flushSeg),
    .flushOff(flushOff), .byteValid(byteValid), .byteData(byteData), .byteReady(byteReady),
    .ipOut(ipOut), .dataReq(dataReq), .dataWe(dataWe), .dataByte(dataByte),
    .dataAddr(dataAddr), .dataWdata(dataWdata), .dataDone(dataDone), .dataRdata(dataRdata),
    .memReq(memReq), .memAddr(memAddr), .memWe(memWe), .memByte(memByte),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] mb(input logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h5A;
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pushStream(input logic [15:0] s, input logic [15:0] o, input int n);
    for (int i = 0; i < n; i++) begin
      logic [15:0] off;
      off = o + 16'(i);
      expByte.push_back(mb(phys(s, off)));
      expIp.push_back(off);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doFlush(input logic [15:0] s, input logic [15:0] o);
    @(negedge clk);
    flushReq = 1'b1; flushSeg = s; flushOff = o;
    expByte.delete(); expIp.delete();
    pushStream(s, o, 80);
    @(negedge clk);
    flushReq = 1'b0;
    #2 check(!byteValid, "R8 buffer empty after flush", 32'(byteValid), 32'd0);
  endtask

  task automatic popOne();
    @(negedge clk); byteReady = 1'b1;
    @(negedge clk); byteReady = 1'b0;
  endtask

  task automatic doData(input logic [19:0] a, input logic we, input logic bm, input logic [15:0] wd,
                        input logic fl, input logic [15:0] fs, input logic [15:0] fo);
    int mark;
    bit got;
    @(negedge clk);
    dataReq = 1'b1; dataAddr = a; dataWe = we; dataByte = bm; dataWdata = wd;
    if (fl) begin
      flushReq = 1'b1; flushSeg = fs; flushOff = fo;
      expByte.delete(); expIp.delete();
      pushStream(fs, fo, 80);
    end
    #2 mark = logAddr.size();
    got = 1'b0;
    for (int k = 0; k < 100 && !got; k++) begin
      @(negedge clk);
      flushReq = 1'b0;
      #2 if (dataDone) got = 1'b1;
    end
    check(got, "R7 dataDone seen", 32'(got), 32'd1);
    if (!we) check(dataRdata == {mb({a[19:1], 1'b1}), mb({a[19:1], 1'b0})}, "R7 dataRdata",
                   32'(dataRdata), 32'({mb({a[19:1], 1'b1}), mb({a[19:1], 1'b0})}));
    dataReq = 1'b0;
    check(logAddr.size() > mark, "R7 request logged", 32'(logAddr.size()), 32'(mark + 1));
    if (logAddr.size() > mark) begin
      check(logAddr[mark] == a, "R7 data access goes first (addr)", 32'(logAddr[mark]), 32'(a));
      check(logWe[mark] == we && logByte[mark] == bm, "R7 data access kind",
            32'({logWe[mark], logByte[mark]}), 32'({we, bm}));
      if (we) check(logWdata[mark] == wd, "R7 write data", 32'(logWdata[mark]), 32'(wd));
    end
  endtask

  // memory responder
  initial begin
    bit busy;
    int waitCnt;
    logic [19:0] hAddr;
    logic hByte, hWe;
    busy = 1'b0; waitCnt = 0; hAddr = '0; hByte = 1'b0; hWe = 1'b0;
    forever begin
      @(negedge clk); #1;
      if (memAck) memAck = 1'b0;
      else if (memReq && rstN) begin
        if (!busy) begin
          busy = 1'b1; waitCnt = 0;
          hAddr = memAddr; hByte = memByte; hWe = memWe;
          logAddr.push_back(memAddr); logByte.push_back(memByte);
          logWe.push_back(memWe); logWdata.push_back(memWdata);
        end else begin
          check(memAddr == hAddr && memByte == hByte && memWe == hWe, "R11 request stable",
                32'({memWe, memByte, memAddr}), 32'({hWe, hByte, hAddr}));
        end
        if (waitCnt >= lat) begin
          memAck = 1'b1;
          memRdata = busWide ? {mb({hAddr[19:1], 1'b1}), mb({hAddr[19:1], 1'b0})}
                             : {8'h00, mb(hAddr)};
          busy = 1'b0;
        end else waitCnt++;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rstN && byteValid && byteReady && !flushReq) begin
        if (expByte.size() == 0) check(1'b0, "R3 unexpected byte", 32'(byteData), 32'd0);
        else begin
          logic [7:0] eb;
          logic [15:0] ei;
          eb = expByte.pop_front();
          ei = expIp.pop_front();
          check(byteData == eb, "R3 byte order", 32'(byteData), 32'(eb));
          check(ipOut == ei, "R10 ipOut", 32'(ipOut), 32'(ei));
        end
      end
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 20000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int n0;
    int mark;
    pushStream(16'hFFFF, 16'h0000, 200);
    waitCycles(2);
    #2;
    check(!byteValid, "R1 byteValid in reset", 32'(byteValid), 32'd0);
    check(!memReq, "R1 memReq in reset", 32'(memReq), 32'd0);
    check(ipOut == 16'h0000, "R1 ipOut in reset", 32'(ipOut), 32'd0);
    @(negedge clk); rstN = 1'b1;
    waitCycles(3);
    check(logAddr.size() > 0 && logAddr[0] == 20'hFFFF0, "R1 R2 first fetch address",
          32'(logAddr.size() > 0 ? logAddr[0] : 20'h0), 32'h0FFFF0);
    check(logAddr.size() > 0 && logByte[0] == 1'b0, "R4 even fetch is word", 32'(logByte[0]), 32'd0);

    // streaming with irregular consumer
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); byteReady = (i % 3 != 0);
    end
    @(negedge clk); byteReady = 1'b0;

    // fill thresholds in 16-bit mode
    waitCycles(30);
    check(byteValid, "R3 full buffer valid", 32'(byteValid), 32'd1);
    n0 = logAddr.size();
    waitCycles(10);
    check(logAddr.size() == n0, "R4 no fetch when full", 32'(logAddr.size()), 32'(n0));
    popOne();
    waitCycles(8);
    check(logAddr.size() == n0, "R4 no word fetch with one free", 32'(logAddr.size()), 32'(n0));
    popOne();
    waitCycles(8);
    check(logAddr.size() == n0 + 1, "R4 fetch with two free", 32'(logAddr.size()), 32'(n0 + 1));
    check(logByte[logByte.size()-1] == 1'b0, "R4 word access", 32'(logByte[logByte.size()-1]), 32'd0);

    // flush while a fetch is in flight, to an odd offset
    lat = 6;
    byteReady = 1'b1;
    popOne();
    while (!memReq) @(negedge clk);
    @(negedge clk);
    byteReady = 1'b1;
    mark = logAddr.size();
    doFlush(16'h5000, 16'h4321);
    lat = 1;
    waitCycles(30);
    check(logAddr.size() >= mark + 2, "R8 refetch after flush", 32'(logAddr.size()), 32'(mark + 2));
    if (logAddr.size() >= mark + 2) begin
      check(logAddr[mark] == 20'h54321, "R2 segment and offset sum", 32'(logAddr[mark]), 32'h54321);
      check(logByte[mark] == 1'b1, "R5 odd fetch is byte", 32'(logByte[mark]), 32'd1);
      check(logAddr[mark+1] == 20'h54322, "R5 realigned next fetch", 32'(logAddr[mark+1]), 32'h54322);
      check(logByte[mark+1] == 1'b0, "R5 realigned word access", 32'(logByte[mark+1]), 32'd0);
    end

    // 8-bit bus mode
    @(negedge clk); busWide = 1'b0; byteReady = 1'b0;
    lat = 2;
    doFlush(16'h1234, 16'h0005);
    waitCycles(40);
    check(byteValid, "R6 buffer filled", 32'(byteValid), 32'd1);
    n0 = logAddr.size();
    waitCycles(8);
    check(logAddr.size() == n0, "R6 no fetch when full", 32'(logAddr.size()), 32'(n0));
    popOne();
    waitCycles(8);
    check(logAddr.size() == n0 + 1, "R6 fetch with one free", 32'(logAddr.size()), 32'(n0 + 1));
    check(logByte[logByte.size()-1] == 1'b1, "R6 byte access", 32'(logByte[logByte.size()-1]), 32'd1);
    check(logAddr[logAddr.size()-1] == 20'h1234B, "R6 fetch address", 32'(logAddr[logAddr.size()-1]), 32'h1234B);
    @(negedge clk); byteReady = 1'b1;
    waitCycles(30);

    // data priority: simultaneous with flush, then behind an outstanding fetch
    @(negedge clk); busWide = 1'b1;
    lat = 1;
    doData(20'h0ABCE, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h3000, 16'h0010);
    waitCycles(10);
    lat = 4;
    while (!(memReq && !memWe)) @(negedge clk);
    doData(20'h12346, 1'b1, 1'b1, 16'h00A5, 1'b0, 16'h0, 16'h0);
    waitCycles(20);

    // offset wrap inside a segment
    lat = 1;
    doFlush(16'h2000, 16'hFFFC);
    mark = logAddr.size();
    waitCycles(20);
    check(logAddr.size() >= mark + 3, "R9 fetches around wrap", 32'(logAddr.size()), 32'(mark + 3));
    if (logAddr.size() >= mark + 3) begin
      check(logAddr[mark] == 20'h2FFFC, "R9 before wrap", 32'(logAddr[mark]), 32'h2FFFC);
      check(logAddr[mark+2] == 20'h20000, "R9 wrapped, segment kept", 32'(logAddr[mark+2]), 32'h20000);
    end
    @(negedge clk); byteReady = 1'b0;
    waitCycles(5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule